// File: doc/BRIEF.md
# Output-Compare PWM Timer

This block generates a pulse-width-modulated waveform from a 16-bit counter and two compare registers. One register, the period compare, fixes the length of a cycle. The other, the edge compare, places the single transition inside that cycle. The counter advances once per tick of a selectable prescaler. It begins each cycle at the preset value 0xFFFC, so a cycle that reloads on period value P lasts P+5 ticks. At the period match the output takes one programmed level, and at the edge match it takes the other. The period match also raises a flag, which can request an interrupt.

Software reaches the block through an 8-bit register port with separate strobes for writing and reading. Each 16-bit compare register is loaded as a high byte and a low byte. Writing the high byte suspends that compare until the low byte arrives, so a half-updated value can never produce a match. Compare order follows the counter's path from 0xFFFC through 0xFFFF, then 0x0000 and upward. As a result 0x0000 counts as later than 0xFFFC..0xFFFF.

Top module: `oc_pwm_timer`

## Requirements
- R1: After reset, pwm_o is 0, irq_o is 0, the control and status registers read 0x00, and both compare registers read 0xFFFF.
- R2: Register addresses: 0 control, 1 edge high byte, 2 edge low byte, 3 period high byte, 4 period low byte, 5 status. Control bits: [0] edge level, [1] period level, [2] PWM enable, [3] one-pulse enable, [5:4] prescale select, [6] shared interrupt enable, [7] period interrupt enable. The control and compare registers read back what was written.
- R3: Prescale select 00 divides by 4, 01 by 8, 10 by 2 and 11 by 1. The counter advances once per prescaled tick.
- R4: With PWM enabled, the counter starts at 0xFFFC and reloads to 0xFFFC on a period match. One cycle lasts (P+5)×div clocks.
- R5: An edge match drives pwm_o to the edge level, and a period match drives it to the period level. The period level is held for (E+5)×div clocks and the edge level for (P−E)×div clocks, with the offsets counted from 0xFFFC.
- R6: After a high-byte write to a compare register, that compare never matches until its low byte is written.
- R7: When the edge value equals the period value, pwm_o inverts at every period match, giving a square wave with halves of (P+5)×div clocks.
- R8: When the edge value lies after the period value in counter order (0xFFFC..0xFFFF first, then 0x0000 upward), pwm_o stays at the period level.
- R9: A period value of 0xFFFC holds the counter at 0xFFFC and pwm_o at the period level. An edge value of 0xFFFC gives a normal waveform of 1×div and (P+4)×div clocks.
- R10: Status bit 0 is set on every period match. Status bit 1, the edge flag, always reads 0.
- R11: Status bit 0 clears only when 1 is written to it after a status read that saw it set. A write of 1 with no such read leaves it set.
- R12: irq_o is high while status bit 0 is set and either control bit 6 or control bit 7 is set.
- R13: With PWM disabled, the counter is held at 0xFFFC, pwm_o holds its value and the flag is not set. With PWM enabled, the one-pulse enable has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed to arm the flag clear) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | Period-match interrupt request |

## Verification
The waveform is measured as run lengths of pwm_o and compared with lengths worked out from the compare values and the divider. Normal and inverted level pairs are used to confirm which match drives which level, and all four prescale codes are used to confirm the divide ratios. Equal compares, an edge value of 0x0000 against a period of 0xFFFF and the reverse, and each compare at 0xFFFC separate the toggle, no-waveform, wrap-ordering and stuck-counter cases. A high-byte-only write while the block is running shows whether the interlock freezes the edge. A write-before-read sequence on the status register shows whether the flag clear is correctly gated.

// File: rtl/oc_pwm_pkg.sv
package oc_pwm_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 3;
    localparam int N_CMP  = 2;

    localparam logic [CNT_W-1:0] CNT_PRESET = 16'hFFFC;
    localparam logic [CNT_W-1:0] CMP_RESET  = 16'hFFFF;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    localparam int CMP_EDGE = 0;
    localparam int CMP_PER  = 1;

    typedef struct packed {
        logic       ie_per;
        logic       ie_any;
        logic [1:0] psel;
        logic       opm_en;
        logic       pwm_en;
        logic       lvl_per;
        logic       lvl_edge;
    } ctrl_t;

    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
        case (sel)
            2'b00:   div_last = PRE_W'(3);
            2'b01:   div_last = PRE_W'(7);
            2'b10:   div_last = PRE_W'(1);
            default: div_last = PRE_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/oc_pwm_prescaler.sv
module oc_pwm_prescaler
    import oc_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q >= div_last(sel));
        pre_d = pre_q + PRE_W'(1);
        if (!run || tick) pre_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/oc_pwm_cmpreg.sv
module oc_pwm_cmpreg
    import oc_pwm_pkg::*;
#(
    parameter logic [CNT_W-1:0] RESET_VAL = CMP_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] data,
    output logic [CNT_W-1:0]  value,
    output logic              armed
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             armed;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi) begin
            st_d.val[CNT_W-1:BYTE_W] = data;
            st_d.armed               = 1'b0;
        end
        if (wr_lo) begin
            st_d.val[BYTE_W-1:0] = data;
            st_d.armed           = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RESET_VAL, armed: 1'b1};
        else        st_q <= st_d;
    end

    assign value = st_q.val;
    assign armed = st_q.armed;
endmodule

// File: rtl/oc_pwm_timer.sv
module oc_pwm_timer
    import oc_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              pwm_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             flag;
        logic             clr_armed;
        ctrl_t            ctrl;
    } st_t;

    st_t st_d, st_q;

    logic                 tick;
    logic [CNT_W-1:0]     cmp_val [N_CMP];
    logic [N_CMP-1:0]     cmp_armed;
    logic [N_CMP-1:0]     cmp_hit;
    logic                 edge_hit, per_hit;
    logic                 pwm_on;
    logic [CNT_W-1:0]     cnt_cur;
    logic                 flag_cur;
    logic                 stat_rd, stat_wr;

    assign pwm_on   = st_q.ctrl.pwm_en;
    assign cnt_cur  = st_q.cnt;
    assign flag_cur = st_q.flag;

    oc_pwm_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pwm_on),
        .sel   (st_q.ctrl.psel),
        .tick  (tick)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(1 + 2 * i);
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 + 2 * i);
        oc_pwm_cmpreg #(.RESET_VAL(CMP_RESET)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hi (wr_en && addr == HI_ADDR),
            .wr_lo (wr_en && addr == LO_ADDR),
            .data  (wdata),
            .value (cmp_val[i]),
            .armed (cmp_armed[i])
        );
        assign cmp_hit[i] = tick && pwm_on && cmp_armed[i] && (st_q.cnt == cmp_val[i]);
    end

    assign edge_hit = cmp_hit[CMP_EDGE];
    assign per_hit  = cmp_hit[CMP_PER];
    assign stat_rd  = rd_en && addr == A_STAT;
    assign stat_wr  = wr_en && addr == A_STAT;

    always_comb begin
        st_d = st_q;

        if (wr_en && addr == A_CTRL) st_d.ctrl = ctrl_t'(wdata);

        // counter: held at preset while idle, reloads on period match
        if (!pwm_on || per_hit) st_d.cnt = CNT_PRESET;
        else if (tick)          st_d.cnt = st_q.cnt + CNT_W'(1);

        // output level
        if (edge_hit && per_hit) st_d.out = ~st_q.out;
        else if (per_hit)        st_d.out = st_q.ctrl.lvl_per;
        else if (edge_hit)       st_d.out = st_q.ctrl.lvl_edge;

        // flag with read-then-write-one clear
        if (stat_rd && st_q.flag) st_d.clr_armed = 1'b1;
        if (stat_wr && wdata[0] && st_q.clr_armed) begin
            st_d.flag      = 1'b0;
            st_d.clr_armed = 1'b0;
        end
        if (per_hit) begin
            st_d.flag      = 1'b1;
            st_d.clr_armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CNT_PRESET, out: 1'b0, flag: 1'b0,
                              clr_armed: 1'b0, ctrl: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = st_q.ctrl;
            3'd1:    rdata = cmp_val[CMP_EDGE][CNT_W-1:BYTE_W];
            3'd2:    rdata = cmp_val[CMP_EDGE][BYTE_W-1:0];
            3'd3:    rdata = cmp_val[CMP_PER][CNT_W-1:BYTE_W];
            3'd4:    rdata = cmp_val[CMP_PER][BYTE_W-1:0];
            3'd5:    rdata = {{(BYTE_W-2){1'b0}}, 1'b0, st_q.flag};
            default: rdata = '0;
        endcase
    end

    assign pwm_o = st_q.out;
    assign irq_o = st_q.flag && (st_q.ctrl.ie_any || st_q.ctrl.ie_per);
endmodule

// File: rtl/oc_pwm_chk.sv
module oc_pwm_chk
    import oc_pwm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pwm_on,
    input logic [CNT_W-1:0] cnt,
    input logic             per_hit,
    input logic             edge_armed,
    input logic             pwm_o,
    input logic             irq_o,
    input logic             flag
);
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> cnt == CNT_PRESET);

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pwm_on && !per_hit) |=> cnt == $past(cnt) + CNT_W'(1));

    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_on |=> cnt == CNT_PRESET);

    a_r6_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_armed && !per_hit) |=> $stable(pwm_o));

    a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);

    a_r10_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(per_hit));
endmodule

bind oc_pwm_timer oc_pwm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pwm_on     (pwm_on),
    .cnt        (cnt_cur),
    .per_hit    (per_hit),
    .edge_armed (cmp_armed[0]),
    .pwm_o      (pwm_o),
    .irq_o      (irq_o),
    .flag       (flag_cur)
);

// File: tb/oc_pwm_timer_bench.sv
module oc_pwm_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pwm_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_busy = 1'b0;

    typedef struct {
        bit    lvl;
        int    len;
        bit    first;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    oc_pwm_timer u_oc_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] mk(bit le, bit lp, bit pwm, bit opm,
                                       bit [1:0] ps, bit ia, bit ip);
        return {ip, ia, ps, opm, pwm, lp, le};
    endfunction

    function automatic int key(input logic [15:0] v);
        return int'(16'(v + 16'd4));
    endfunction

    task automatic push(bit lvl, int len, bit first, string tag);
        exp_t e;
        e.lvl = lvl; e.len = len; e.first = first; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic drain();
        while (sbq.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] ctl, input logic [15:0] e, input logic [15:0] p);
        wr(3'd0, ctl & 8'hFB);
        wr(3'd1, e[15:8]); wr(3'd2, e[7:0]);
        wr(3'd3, p[15:8]); wr(3'd4, p[7:0]);
        wr(3'd0, ctl);
    endtask

    // expected runs: period level for key(E)+1 ticks, edge level for key(P)-key(E)
    task automatic push_wave(bit le, bit lp, logic [15:0] e, logic [15:0] p,
                             int dv, string tag);
        int a = (key(e) + 1) * dv;
        int b = (key(p) - key(e)) * dv;
        push(lp, a, 1'b1, tag); push(le, b, 1'b0, tag);
        push(lp, a, 1'b0, tag); push(le, b, 1'b0, tag);
        drain();
    endtask

    task automatic hold_check(input string tag, input bit lvl, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o !== lvl) bad++;
        end
        check(tag, bad, 0);
    endtask

    // monitor: pops expected runs and measures pwm_o
    initial begin
        exp_t e;
        int   len;
        forever begin
            while (sbq.size() == 0) @(negedge clk);
            mon_busy = 1'b1;
            e = sbq.pop_front();
            if (e.first) begin
                while (pwm_o === e.lvl) @(negedge clk);
                while (pwm_o !== e.lvl) @(negedge clk);
            end
            len = 0;
            while (pwm_o === e.lvl && len < 4000) begin
                len++;
                @(negedge clk);
            end
            check(e.tag, len, e.len);
            mon_busy = (sbq.size() != 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pwm_o", int'(pwm_o), 0);
        check("R1 irq_o", int'(irq_o), 0);
        rd(3'd0, d); check("R1 ctrl", d, 8'h00);
        rd(3'd1, d); check("R1 edge hi", d, 8'hFF);
        rd(3'd4, d); check("R1 period lo", d, 8'hFF);
        rd(3'd5, d); check("R1 status", d, 8'h00);

        // R2 readback
        wr(3'd0, 8'hC3); rd(3'd0, d); check("R2 ctrl readback", d, 8'hC3);
        wr(3'd3, 8'h12); wr(3'd4, 8'h34);
        rd(3'd3, d); check("R2 period hi", d, 8'h12);
        rd(3'd4, d); check("R2 period lo", d, 8'h34);
        wr(3'd0, 8'h00);

        // R4 R5 basic, div1
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'd1, 16'd3);
        push_wave(0, 1, 16'd1, 16'd3, 1, "R4 R5 E1 P3 div1");

        // R5 inverted levels, R3 div2
        setup(mk(1, 0, 1, 0, 2'b10, 0, 0), 16'd2, 16'd5);
        push_wave(1, 0, 16'd2, 16'd5, 2, "R5 R3 inverted div2");

        // R3 div4 and div8
        setup(mk(0, 1, 1, 0, 2'b00, 0, 0), 16'd1, 16'd3);
        push_wave(0, 1, 16'd1, 16'd3, 4, "R3 div4");
        setup(mk(0, 1, 1, 0, 2'b01, 0, 0), 16'd1, 16'd3);
        push_wave(0, 1, 16'd1, 16'd3, 8, "R3 div8");

        // R13 one-pulse enable ignored with PWM on
        setup(mk(0, 1, 1, 1, 2'b11, 0, 0), 16'd1, 16'd3);
        push_wave(0, 1, 16'd1, 16'd3, 1, "R13 opm ignored");

        // R7 equal compares -> square wave
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'd3, 16'd3);
        push(1'b1, 8, 1'b1, "R7 square"); push(1'b0, 8, 1'b0, "R7 square");
        push(1'b1, 8, 1'b0, "R7 square"); drain();

        // R8 edge 0x0000 later than period 0xFFFF
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'h0000, 16'hFFFF);
        repeat (12) @(negedge clk);
        hold_check("R8 no waveform E0000 PFFFF", 1'b1, 40);
        // R8 reverse: edge 0xFFFF before period 0x0000
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'hFFFF, 16'h0000);
        push_wave(0, 1, 16'hFFFF, 16'h0000, 1, "R8 wrap order");

        // R9 edge at preset works
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'hFFFC, 16'd3);
        push_wave(0, 1, 16'hFFFC, 16'd3, 1, "R9 edge FFFC");
        // R9 period at preset sticks
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'd1, 16'hFFFC);
        repeat (6) @(negedge clk);
        hold_check("R9 period FFFC stuck", 1'b1, 40);

        // R6 interlock on edge compare
        setup(mk(0, 1, 1, 0, 2'b11, 0, 0), 16'd1, 16'd3);
        repeat (20) @(negedge clk);
        wr(3'd1, 8'h00);
        repeat (10) @(negedge clk);
        hold_check("R6 edge blocked", 1'b1, 30);
        wr(3'd2, 8'h01);
        push_wave(0, 1, 16'd1, 16'd3, 1, "R6 edge rearmed");

        // R10 flag set, edge flag zero
        rd(3'd5, d); check("R10 status while running", d, 8'h01);

        // R11 R12: stop, let a fresh match disarm the clear, then test
        repeat (10) @(negedge clk);
        wr(3'd0, mk(0, 1, 0, 0, 2'b11, 0, 0));
        check("R12 irq off without enables", int'(irq_o), 0);
        wr(3'd5, 8'h01);
        rd(3'd5, d); check("R11 write without read keeps flag", d, 8'h01);
        wr(3'd0, mk(0, 1, 0, 0, 2'b11, 1, 0));
        @(negedge clk); check("R12 irq shared enable", int'(irq_o), 1);
        wr(3'd0, mk(0, 1, 0, 0, 2'b11, 0, 1));
        @(negedge clk); check("R12 irq period enable", int'(irq_o), 1);
        wr(3'd5, 8'h01);
        rd(3'd5, d); check("R11 read then write clears", d, 8'h00);
        check("R12 irq low after clear", int'(irq_o), 0);

        // R13 PWM off: no flag, output holds
        d = 8'(pwm_o);
        hold_check("R13 output holds when off", d[0], 50);
        rd(3'd5, d); check("R13 no flag when off", d, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule